// File: doc/BRIEF.md
# Inactivity Power-Down Controller

This controller tracks how long the system has gone without activity and lets firmware move the system between a full-on state and three power-down levels. In order of increasing savings these levels are Doze, Stand-by and Suspend. Three idle timers reload on every system activity strobe and count down on a prescaled tick. Each timer is programmed separately, so firmware can give them successively longer counts. When a timer reaches zero it sets a status flag and raises a system-management interrupt. The hardware itself never changes state on a timeout. A separate peripheral timer reloads only on the peripheral activity strobe, and it flags when the peripherals have been quiet for long enough.

Firmware changes state by writing a target-state register. Activity seen in any power-down state sets a wake flag and raises the interrupt. While that flag is pending, the block refuses any move to a deeper state. For each state there is a duty-cycle setting for the suspend-request output, full-on included, so performance can be throttled at every level. Each state also has its own power-plane enable mask, which drives the board's plane switches.

Top module: `pdn_ctrl`

## Requirements
- R1: After reset the state is full-on (code 0), the status register is 0, the interrupt and suspend-request outputs are low, and every power-plane enable is high. Every mask and every reload register resets as well: masks to all ones, reload counts to 0.
- R2: Writing address 0 requests a state through data bits [1:0], with 0=full-on, 1=Doze, 2=Stand-by and 3=Suspend. A request for the same or a shallower code is always accepted. A request for a deeper code is accepted only when status bit 3 (wake) is clear. Reading address 0 returns the current state, which takes the new value in the cycle after the write.
- R3: Idle timer i (i=0..2) has its reload count at address 2+i. Writing that address loads the counter. The counter decrements once per prescaled tick, and when it reaches zero it sets status bit i. A count of 0 disables the timer.
- R4: A system activity strobe reloads all three idle timers from their reload registers and leaves the peripheral timer untouched.
- R5: The peripheral timer's reload count sits at address 5. It reloads only on a peripheral activity strobe, and on expiry it sets status bit 4.
- R6: Either activity strobe, when it arrives in a state other than full-on, sets status bit 3 (wake). In full-on the strobes never set bit 3.
- R7: The interrupt output is high whenever any status bit is set. Writing address 1 clears each status bit whose data bit is 1.
- R8: Address 8+s holds the modulation setting for state s, with the on-count in bits [3:0] and the period field P in bits [7:4]. Within every run of P+1 cycles, the suspend request is high for the first min(on, P+1) cycles. An on-count of 0 keeps the output low. The phase restarts when the state changes.
- R9: Address 12+s holds the power-plane mask for state s. The plane outputs equal the mask of the current state, and they update one cycle after the state register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_sys_i | input | 1 | System activity strobe |
| act_per_i | input | 1 | Peripheral activity strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| state_o | output | 2 | Current power state |
| smi_o | output | 1 | System-management interrupt request |
| sus_req_o | output | 1 | Modulated suspend request |
| plane_en_o | output | NPLANE | Power-plane enables |

## Verification
The bench builds the block with PRESC=4, so a tick arrives every four clocks. With that prescale a timer count of 3 to 5 expires within a few dozen cycles, and the bench can bracket each expiry between a cycle where it cannot yet have happened and one where it must have. Because the default 4-bit modulation fields and 4 planes are kept, a sweep over two full periods can count the exact number of high cycles, including the cases where the on-count is zero and where it exceeds the period.

// File: rtl/pdn_pkg.sv
// Package: shared types and the register map of the power-down controller.
// Assumes a 4-bit register address space.
package pdn_pkg;
    typedef enum logic [1:0] {
        ST_FULL = 2'd0,
        ST_DOZE = 2'd1,
        ST_STBY = 2'd2,
        ST_SUSP = 2'd3
    } pdn_state_e;

    localparam int NSTATE   = 4;
    localparam int NSYS_TMR = 3;
    localparam int NTMR     = NSYS_TMR + 1;  // three idle timers + peripheral timer
    localparam int STAT_W   = 5;
    localparam int WAKE_BIT = 3;
    localparam int PER_BIT  = 4;
    localparam int ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] A_STATE = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_TMR0  = 4'd2;
    localparam logic [ADDR_W-1:0] A_PER   = 4'd5;
    localparam logic [1:0]        G_MOD   = 2'b10;  // addresses 8..11
    localparam logic [1:0]        G_MASK  = 2'b11;  // addresses 12..15
endpackage

// File: rtl/pdn_prescale.sv
// Prescaler: produces a one-cycle tick every DIV clocks.
// Assumes DIV >= 2.
module pdn_prescale #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pdn_idle_timer.sv
// Idle timer: loads a count, decrements on each tick, and pulses
// expire_o on the tick that takes it from 1 to 0. A load wins over a tick.
// A zero count never expires.
module pdn_idle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          tick_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_q;

    // Count register: reload or decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load_i)                  cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = tick_i && !load_i && (cnt_q == CW'(1));
endmodule

// File: rtl/pdn_susp_mod.sv
// Suspend-request modulator: a phase counter runs over per_i+1 cycles,
// and the output is high while phase < on_i. restart_i zeroes the phase.
module pdn_susp_mod #(
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [MW-1:0] on_i,
    input  logic [MW-1:0] per_i,
    output logic          sus_o
);
    logic [MW-1:0] phase_q;

    // Phase counter with wrap at the period field.
    always_ff @(posedge clk) begin
        if (!rst_n)               phase_q <= '0;
        else if (restart_i)       phase_q <= '0;
        else if (phase_q >= per_i) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    assign sus_o = (phase_q < on_i);
endmodule

// File: rtl/pdn_ctrl.sv
// Top of the inactivity power-down controller. It holds the register file,
// the state register, the status/interrupt logic and the per-state plane
// masks, and it instances the prescaler, the timers and the modulator.
// Assumes DATA_W covers CNT_W, 2*MOD_W, NPLANE and the status width.
module pdn_ctrl
    import pdn_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MOD_W  = 4,
    parameter int NPLANE = 4,
    parameter int PRESC  = 1024,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_sys_i,
    input  logic              act_per_i,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [3:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [1:0]        state_o,
    output logic              smi_o,
    output logic              sus_req_o,
    output logic [NPLANE-1:0] plane_en_o
);
    localparam int MODCFG_W = 2 * MOD_W;

    pdn_state_e        state_q, state_d;
    logic [STAT_W-1:0] status_q;
    logic [CNT_W-1:0]  reload_q [NTMR];
    logic [MODCFG_W-1:0] mod_q  [NSTATE];
    logic [NPLANE-1:0] mask_q   [NSTATE];
    logic [NPLANE-1:0] plane_q;
    logic [NPLANE-1:0] mask_cur;
    logic [MOD_W-1:0]  on_cur, per_cur;
    logic [NTMR-1:0]   expire;
    logic [STAT_W-1:0] stat_set, stat_clr;
    logic              tick, wake, state_chg;
    logic              wr_state, wr_stat;

    assign wr_state = wr_en_i && (wr_addr_i == A_STATE);
    assign wr_stat  = wr_en_i && (wr_addr_i == A_STAT);

    pdn_prescale #(.DIV(PRESC)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    // Timers: indices below NSYS_TMR follow system activity, the last one peripheral.
    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        localparam logic [3:0] MY_ADDR = (i < NSYS_TMR) ? 4'(A_TMR0 + i) : A_PER;
        logic wr_hit, act_hit, load;
        logic [CNT_W-1:0] load_val;
        assign wr_hit  = wr_en_i && (wr_addr_i == MY_ADDR);
        if (i < NSYS_TMR) begin : g_sys
            assign act_hit = act_sys_i;
        end else begin : g_per
            assign act_hit = act_per_i;
        end
        assign load     = wr_hit || act_hit;
        assign load_val = wr_hit ? wr_data_i[CNT_W-1:0] : reload_q[i];

        // Reload register for this timer.
        always_ff @(posedge clk) begin
            if (!rst_n)      reload_q[i] <= '0;
            else if (wr_hit) reload_q[i] <= wr_data_i[CNT_W-1:0];
        end

        pdn_idle_timer #(.CW(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .load_i(load),
            .load_val_i(load_val), .tick_i(tick), .expire_o(expire[i])
        );
    end

    // Per-state modulation and plane-mask registers.
    for (genvar s = 0; s < NSTATE; s++) begin : g_cfg
        // Configuration registers of state s.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mod_q[s]  <= '0;
                mask_q[s] <= '1;
            end else if (wr_en_i && wr_addr_i[1:0] == 2'(s)) begin
                if (wr_addr_i[3:2] == G_MOD)  mod_q[s]  <= wr_data_i[MODCFG_W-1:0];
                if (wr_addr_i[3:2] == G_MASK) mask_q[s] <= wr_data_i[NPLANE-1:0];
            end
        end
    end

    // Next-state: shallower or equal always accepted, deeper only without pending wake.
    always_comb begin
        state_d = state_q;
        if (wr_state) begin
            if (wr_data_i[1:0] <= state_q || !status_q[WAKE_BIT])
                state_d = pdn_state_e'(wr_data_i[1:0]);
        end
    end
    assign state_chg = (state_d != state_q);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FULL;
        else        state_q <= state_d;
    end

    // Status events and write-one-to-clear mask.
    assign wake = (act_sys_i || act_per_i) && (state_q != ST_FULL);
    always_comb begin
        stat_set = '0;
        stat_set[NSYS_TMR-1:0] = expire[NSYS_TMR-1:0];
        stat_set[WAKE_BIT]     = wake;
        stat_set[PER_BIT]      = expire[NTMR-1];
        stat_clr = wr_stat ? wr_data_i[STAT_W-1:0] : '0;
    end

    // Status register: a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~stat_clr) | stat_set;
    end

    assign mask_cur = mask_q[state_q];
    assign on_cur   = mod_q[state_q][MOD_W-1:0];
    assign per_cur  = mod_q[state_q][MODCFG_W-1:MOD_W];

    // Plane enables follow the current state's mask one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) plane_q <= '1;
        else        plane_q <= mask_cur;
    end

    pdn_susp_mod #(.MW(MOD_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .restart_i(state_chg),
        .on_i(on_cur), .per_i(per_cur), .sus_o(sus_req_o)
    );

    // Register read mux.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == A_STATE)                   rd_data_o = DATA_W'(state_q);
        else if (rd_addr_i == A_STAT)               rd_data_o = DATA_W'(status_q);
        else if (rd_addr_i >= A_TMR0 && rd_addr_i <= A_PER)
            rd_data_o = DATA_W'(reload_q[rd_addr_i - A_TMR0]);
        else if (rd_addr_i[3:2] == G_MOD)           rd_data_o = DATA_W'(mod_q[rd_addr_i[1:0]]);
        else if (rd_addr_i[3:2] == G_MASK)          rd_data_o = DATA_W'(mask_q[rd_addr_i[1:0]]);
    end

    assign state_o    = state_q;
    assign smi_o      = |status_q;
    assign plane_en_o = plane_q;
endmodule

// File: rtl/pdn_ctrl_chk.sv
// Checker for pdn_ctrl: temporal properties across its submodules.
// Attached to every instance of the top through the bind below.
module pdn_ctrl_chk #(
    parameter int NPLANE = 4,
    parameter int MOD_W  = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              act_sys,
    input logic              act_per,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        state,
    input logic [4:0]        status,
    input logic              smi,
    input logic              sus_req,
    input logic [MOD_W-1:0]  on_cur,
    input logic [NPLANE-1:0] mask_cur,
    input logic [NPLANE-1:0] plane_en
);
    // R6: activity outside full-on leaves the wake flag set.
    p_wake_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_sys || act_per) && state != 2'd0) |=> status[3]);

    // R2: a deeper request with wake pending leaves the state unchanged.
    p_deeper_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd0 && wr_data[1:0] > state && status[3]) |=> $stable(state));

    // R7: the interrupt stays up until a status write.
    p_smi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smi && !(wr_en && wr_addr == 4'd1)) |=> smi);

    // R9: after a state change the planes show the new state's mask.
    p_plane_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |=> (plane_en == $past(mask_cur)));

    // R8: a zero on-count keeps the suspend request low.
    p_on_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (on_cur == '0) |-> !sus_req);
endmodule

bind pdn_ctrl pdn_ctrl_chk #(.NPLANE(NPLANE), .MOD_W(MOD_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .act_sys(act_sys_i), .act_per(act_per_i),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .state(state_q), .status(status_q), .smi(smi_o), .sus_req(sus_req_o),
    .on_cur(on_cur), .mask_cur(mask_cur), .plane_en(plane_en_o)
);

// File: tb/pdn_ctrl_tb.sv
module pdn_ctrl_tb_top;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              act_sys = 1'b0, act_per = 1'b0, wr_en = 1'b0;
    logic [3:0]        wr_addr = '0, rd_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [1:0]        state;
    logic              smi, sus_req;
    logic [3:0]        plane_en;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    pdn_ctrl #(.PRESC(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .act_sys_i(act_sys), .act_per_i(act_per),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .state_o(state),
        .smi_o(smi), .sus_req_o(sus_req), .plane_en_o(plane_en)
    );

    typedef struct packed {
        logic       act;
        logic [1:0] tgt;
        logic [1:0] est;
        logic       ewake;
    } vec_t;

    // Starting from full-on with all timers disabled.
    localparam vec_t VEC [0:7] = '{
        '{1'b0, 2'd2, 2'd2, 1'b0},  // deeper, no wake: accepted
        '{1'b1, 2'd3, 2'd2, 1'b1},  // wake pending: deeper refused
        '{1'b0, 2'd3, 2'd3, 1'b0},  // wake cleared: deeper accepted
        '{1'b1, 2'd1, 2'd1, 1'b1},  // shallower accepted despite wake
        '{1'b0, 2'd1, 2'd1, 1'b0},  // same state
        '{1'b1, 2'd0, 2'd0, 1'b1},  // back to full-on
        '{1'b1, 2'd2, 2'd2, 1'b0},  // activity in full-on: no wake
        '{1'b0, 2'd0, 2'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DATA_W-1:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic pulse_sys();
        @(negedge clk); act_sys = 1'b1; @(negedge clk); act_sys = 1'b0;
    endtask

    task automatic pulse_per();
        @(negedge clk); act_per = 1'b1; @(negedge clk); act_per = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_sus(input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); if (sus_req) hi++;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        int hi;
        idle(3); rst_n = 1'b1; idle(1);

        // R1 reset state
        chk("R1 state", state, 0);
        chk("R1 smi", smi, 0);
        chk("R1 sus_req", sus_req, 0);
        chk("R1 plane_en", plane_en, 4'hF);
        rd(4'd1, d); chk("R1 status", d, 0);

        // R3 idle timer 1 expiry window
        wr(4'd3, 16'd3);
        idle(2); rd(4'd1, d); chk("R3 not yet expired", d[1], 0);
        idle(12); rd(4'd1, d); chk("R3 timer1 expired", d[1], 1);
        chk("R3 disabled timers silent", {d[2], d[0]}, 0);
        chk("R7 smi on status", smi, 1);
        wr(4'd1, 16'h0002);
        chk("R7 w1c clears smi", smi, 0);
        wr(4'd3, 16'd0);

        // R4 system activity reloads idle timer 0
        wr(4'd2, 16'd5);
        repeat (3) begin idle(8); pulse_sys(); end
        idle(8); rd(4'd1, d); chk("R4 reload holds off expiry", d[0], 0);
        idle(25); rd(4'd1, d); chk("R4 timer0 expires after quiet", d[0], 1);
        wr(4'd2, 16'd0); wr(4'd1, 16'h001F);

        // R5 peripheral timer ignores system activity
        wr(4'd5, 16'd4);
        repeat (5) begin pulse_sys(); idle(4); end
        rd(4'd1, d); chk("R5 per expires under sys activity", d[4], 1);
        wr(4'd1, 16'h001F);
        wr(4'd5, 16'd4);
        repeat (5) begin pulse_per(); idle(4); end
        rd(4'd1, d); chk("R5 per activity reloads", d[4], 0);
        idle(25); rd(4'd1, d); chk("R5 per expiry", d[4], 1);
        chk("R6 no wake in full-on", d[3], 0);
        wr(4'd5, 16'd0); wr(4'd1, 16'h001F);

        // R2 / R6 state table
        for (int i = 0; i < 8; i++) begin
            if (VEC[i].act) pulse_sys();
            wr(4'd0, DATA_W'(VEC[i].tgt));
            rd(4'd0, d); chk($sformatf("R2 vec%0d state", i), d, VEC[i].est);
            chk($sformatf("R2 vec%0d state_o", i), state, VEC[i].est);
            rd(4'd1, d); chk($sformatf("R6 vec%0d wake", i), d[3], VEC[i].ewake);
            wr(4'd1, 16'h001F);
        end

        // R8 modulation in full-on
        wr(4'd8, 16'h0042);
        count_sus(10, hi); chk("R8 on=2 per=4", hi, 4);
        wr(4'd8, 16'h0040);
        count_sus(10, hi); chk("R8 on=0 never", hi, 0);
        wr(4'd8, 16'h0037);
        count_sus(10, hi); chk("R8 on>period always", hi, 10);

        // R9 plane mask, one cycle after state change
        wr(4'd13, 16'h0005);
        chk("R9 full-on mask still", plane_en, 4'hF);
        wr(4'd0, 16'd1);
        chk("R9 planes lag state", plane_en, 4'hF);
        idle(1);
        chk("R9 doze mask", plane_en, 4'h5);
        chk("R8 doze own setting", sus_req, 0);
        wr(4'd0, 16'd0); idle(1);
        chk("R9 back to full mask", plane_en, 4'hF);
        chk("R8 full-on setting", sus_req, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule